// File: doc/BRIEF.md
# Asynchronous Serial Port with Register Access

This block is a full-duplex asynchronous serial port controlled through four word registers: a character register, a status register, a control register and a divisor register. Writing the character register places a character in a transmit holding stage, and the transmitter sends it once the line is free. Reading the same address returns the oldest received character and removes it from a two-entry receive queue.

Each character goes out with a low start bit, then 6 to 9 data bits with the least significant bit first, then an optional parity bit, then a high stop bit. One 16x oversample tick, derived from the system clock and the divisor register, times both directions. The receiver checks the start bit at its centre and samples every later bit at the centre of its cell. Three interrupt lines report received data, a free holding stage and a finished transmission. Each line has its own enable bit.

Top module: `sio_port`

## Requirements
- R1: When idle, `txd` is high. A character is sent as one low start bit, then the data bits with the least significant bit first, then the parity bit if one is selected, then one high stop bit.
- R2: Control bits [6:5] set the number of data bits as 6 + value, which gives 6, 7, 8 or 9. The same length applies to transmit and receive. A received character is returned right-aligned in `rdata` with the upper bits zero.
- R3: Control bits [9:7] set the parity mode: 0 none, 1 even (the total count of ones is even), 2 odd, 3 always 1, 4 always 0. Values 5 to 7 act as none.
- R4: Every bit cell lasts 16 × (divisor + 1) clock cycles. The divisor is held at address 3.
- R5: Status bit 2 (transmit done) is set only after the stop bit has been fully sent while the holding stage is empty. A write to address 0 clears it. Writing address 1 with bit 2 set also clears it.
- R6: Status bit 1 is high while the holding stage is empty. `irq_rx` equals status bit 0 AND control bit 2. `irq_empty` equals status bit 1 AND control bit 3. `irq_txdone` equals status bit 2 AND control bit 4.
- R7: The receiver accepts a start bit only if the line is still low at the centre of the start cell. When a character completes, status bit 0 is set. A read of address 0 with `rd_en` returns the oldest character and removes it. Status bit 0 clears when the queue becomes empty.
- R8: Two received characters can wait in the queue, and they are read back in arrival order. A character that completes while both entries are full is discarded and sets status bit 4 (overrun). Status bit 4 clears on the next read of address 0.
- R9: A character whose stop bit is sampled low is still stored. While that character is the oldest one in the queue, status bit 3 (framing error) is high.
- R10: With control bit 0 (receive enable) low, line activity on `rxd` stores nothing. With control bit 1 (transmit enable) low, `txd` stays high and a written character waits in the holding stage.
- R11: After reset, the status register reads 0x002, `txd` is high and all three interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 character, 1 status, 2 control, 3 divisor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at address 0 it removes the oldest character |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Received-data interrupt |
| irq_empty | output | 1 | Holding-stage-empty interrupt |
| irq_txdone | output | 1 | Transmission-finished interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together, and that `rxd` only changes on whole bit cells timed by the programmed divisor. The bench drives every register access as a single-cycle strobe. It generates each received frame from its own clock count of 16 × (divisor + 1) cycles per bit. The assertions also assume that the control register is not changed while a frame is in flight. For that reason, the stimulus changes the format, the enables and the divisor only after the line has gone quiet.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_ONE   = 3'd3,
    PAR_ZERO  = 3'd4
  } par_e;

  function automatic logic par_used(logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic logic par_value(logic [2:0] m, logic [MAX_BITS-1:0] d, logic [3:0] n);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(n)) x = x ^ d[i];
    case (m)
      3'd1:    return x;
      3'd2:    return ~x;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                en,
  input  logic                hold_full,
  input  logic [MAX_BITS-1:0] hold_data,
  input  logic [3:0]          nbits,
  input  logic [2:0]          pmode,
  output logic                txd,
  output logic                take,
  output logic                frame_end,
  output logic                busy
);
  localparam int SUB_W = $clog2(OVS);
  localparam int FRM_W = MAX_BITS + 3;

  logic             busy_q, busy_d;
  logic [FRM_W-1:0] frm_q, frm_d, frm_new;
  logic [3:0]       len_q, len_d, len_new, idx_q, idx_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             pu, pv;

  always_comb begin
    pu = par_used(pmode);
    pv = par_value(pmode, hold_data, nbits);
    frm_new    = '1;
    frm_new[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nbits)) frm_new[i+1] = hold_data[i];
    for (int i = 0; i < FRM_W; i++)
      if (pu && (i == int'(nbits) + 1)) frm_new[i] = pv;
    len_new = nbits + 4'd2 + {3'b000, pu};
  end

  always_comb begin
    busy_d    = busy_q;
    frm_d     = frm_q;
    len_d     = len_q;
    idx_d     = idx_q;
    sub_d     = sub_q;
    frame_end = 1'b0;
    take      = !busy_q && en && hold_full && tick;
    if (take) begin
      busy_d = 1'b1;
      frm_d  = frm_new;
      len_d  = len_new;
      idx_d  = '0;
      sub_d  = '0;
    end else if (busy_q && tick) begin
      if (sub_q == SUB_W'(OVS - 1)) begin
        sub_d = '0;
        if (idx_q == len_q - 4'd1) begin
          busy_d    = 1'b0;
          frame_end = 1'b1;
        end else begin
          idx_d = idx_q + 4'd1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      frm_q  <= '1;
      len_q  <= '0;
      idx_q  <= '0;
      sub_q  <= '0;
    end else begin
      busy_q <= busy_d;
      frm_q  <= frm_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      sub_q  <= sub_d;
    end

  assign txd  = busy_q ? frm_q[idx_q] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                en,
  input  logic                rxd,
  input  logic [3:0]          nbits,
  input  logic [2:0]          pmode,
  output logic                done,
  output logic                ferr,
  output logic [MAX_BITS-1:0] data
);
  localparam int SUB_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_WAIT} rst_e;

  rst_e                st_q, st_d;
  logic [SUB_W-1:0]    sub_q, sub_d;
  logic [3:0]          idx_q, idx_d, last;
  logic [MAX_BITS-1:0] sh_q, sh_d;

  always_comb begin
    last  = nbits + {3'b000, par_used(pmode)};
    st_d  = st_q;
    sub_d = sub_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    done  = 1'b0;
    ferr  = 1'b0;
    case (st_q)
      R_IDLE:
        if (tick && !rxd) begin
          st_d  = R_START;
          sub_d = '0;
        end
      R_START:
        if (tick) begin
          if (sub_q == SUB_W'(HALF - 1)) begin
            st_d  = rxd ? R_IDLE : R_BITS;
            sub_d = '0;
            idx_d = '0;
            sh_d  = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      R_BITS:
        if (tick) begin
          if (sub_q == SUB_W'(OVS - 1)) begin
            sub_d = '0;
            for (int i = 0; i < MAX_BITS; i++)
              if ((i == int'(idx_q)) && (idx_q < nbits)) sh_d[i] = rxd;
            if (idx_q == last) begin
              done = 1'b1;
              ferr = !rxd;
              st_d = rxd ? R_IDLE : R_WAIT;
            end else begin
              idx_d = idx_q + 4'd1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      default:
        if (rxd) st_d = R_IDLE;
    endcase
    if (!en) begin
      st_d = R_IDLE;
      done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q  <= R_IDLE;
      sub_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end

  assign data = sh_q;
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int BUS_W = 12,
  parameter int OVS   = 16,
  parameter int RXQ_D = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             irq_rx,
  output logic             irq_empty,
  output logic             irq_txdone
);
  localparam int CNT_W  = $clog2(RXQ_D + 1);
  localparam int CTRL_W = 10;

  logic [1:0] rs_q;
  logic       rst_i;
  logic [1:0] rx_s_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) rx_s_q <= '1;
    else        rx_s_q <= {rx_s_q[0], rxd};

  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [BUS_W-1:0]    div_q, div_d;
  logic [MAX_BITS-1:0] hold_q, hold_d;
  logic                hold_full_q, hold_full_d;
  logic                txdone_q, txdone_d;
  logic                ovr_q, ovr_d;
  logic [MAX_BITS-1:0] qd_q [RXQ_D];
  logic [MAX_BITS-1:0] qd_d [RXQ_D];
  logic                qf_q [RXQ_D];
  logic                qf_d [RXQ_D];
  logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_p;

  logic                wr_dat, wr_sta, wr_ctl, wr_div, pop;
  logic                tick, tx_take, tx_end, tx_busy;
  logic                rx_done, rx_ferr;
  logic [MAX_BITS-1:0] rx_data;
  logic [3:0]          nbits;
  logic [2:0]          pmode;
  logic                rx_en, tx_en;

  assign nbits = 4'd6 + {2'b00, ctrl_q[6:5]};
  assign pmode = ctrl_q[9:7];
  assign rx_en = ctrl_q[0];
  assign tx_en = ctrl_q[1];

  sio_baud #(.DIV_W(BUS_W)) u_baud (
    .clk(clk), .rst_n(rst_i), .div(div_q), .tick(tick)
  );

  sio_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(tx_en), .hold_full(hold_full_q),
    .hold_data(hold_q), .nbits(nbits), .pmode(pmode), .txd(txd), .take(tx_take),
    .frame_end(tx_end), .busy(tx_busy)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(rx_en), .rxd(rx_s_q[1]),
    .nbits(nbits), .pmode(pmode), .done(rx_done), .ferr(rx_ferr), .data(rx_data)
  );

  always_comb begin
    wr_dat = wr_en && (addr == 2'd0);
    wr_sta = wr_en && (addr == 2'd1);
    wr_ctl = wr_en && (addr == 2'd2);
    wr_div = wr_en && (addr == 2'd3);
    pop    = rd_en && (addr == 2'd0) && (cnt_q != '0);

    ctrl_d = wr_ctl ? wdata[CTRL_W-1:0] : ctrl_q;
    div_d  = wr_div ? wdata : div_q;

    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    if (tx_take) hold_full_d = 1'b0;
    if (wr_dat) begin
      hold_d      = wdata[MAX_BITS-1:0];
      hold_full_d = 1'b1;
    end

    txdone_d = txdone_q;
    if (tx_end && !hold_full_q)   txdone_d = 1'b1;
    if (wr_sta && wdata[2])       txdone_d = 1'b0;
    if (wr_dat)                   txdone_d = 1'b0;

    for (int i = 0; i < RXQ_D; i++) begin
      qd_d[i] = qd_q[i];
      qf_d[i] = qf_q[i];
    end
    if (pop)
      for (int i = 0; i < RXQ_D - 1; i++) begin
        qd_d[i] = qd_q[i+1];
        qf_d[i] = qf_q[i+1];
      end
    cnt_p = cnt_q - CNT_W'(pop);
    cnt_d = cnt_p;
    ovr_d = pop ? 1'b0 : ovr_q;
    if (rx_done) begin
      if (cnt_p < CNT_W'(RXQ_D)) begin
        for (int i = 0; i < RXQ_D; i++)
          if (CNT_W'(i) == cnt_p) begin
            qd_d[i] = rx_data;
            qf_d[i] = rx_ferr;
          end
        cnt_d = cnt_p + 1'b1;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      ctrl_q      <= '0;
      div_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      txdone_q    <= 1'b0;
      ovr_q       <= 1'b0;
      cnt_q       <= '0;
      for (int i = 0; i < RXQ_D; i++) begin
        qd_q[i] <= '0;
        qf_q[i] <= 1'b0;
      end
    end else begin
      ctrl_q      <= ctrl_d;
      div_q       <= div_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      txdone_q    <= txdone_d;
      ovr_q       <= ovr_d;
      cnt_q       <= cnt_d;
      for (int i = 0; i < RXQ_D; i++) begin
        qd_q[i] <= qd_d[i];
        qf_q[i] <= qf_d[i];
      end
    end

  logic rx_avail, head_ferr;
  logic [4:0] stat;

  always_comb begin
    rx_avail  = (cnt_q != '0);
    head_ferr = qf_q[0] && rx_avail;
    stat      = {ovr_q, head_ferr, txdone_q, !hold_full_q, rx_avail};
    case (addr)
      2'd0:    rdata = BUS_W'(qd_q[0]);
      2'd1:    rdata = BUS_W'(stat);
      2'd2:    rdata = BUS_W'(ctrl_q);
      default: rdata = div_q;
    endcase
    irq_rx     = rx_avail && ctrl_q[2];
    irq_empty  = !hold_full_q && ctrl_q[3];
    irq_txdone = txdone_q && ctrl_q[4];
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             tx_busy,
  input logic             tx_done,
  input logic             hold_full,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             ovr,
  input logic             rx_en,
  input logic             irq_rx,
  input logic             irq_empty
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_done_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (!tx_busy && txd));

  assert_write_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> !tx_done);

  assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH));

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_cnt == CNT_W'(DEPTH)) |=> (ovr && rx_cnt == CNT_W'(DEPTH)));

  assert_rx_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_push);

  assert_rx_irq_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_cnt != '0));

  assert_empty_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> !hold_full);
endmodule

bind sio_port sio_port_chk #(.DEPTH(RXQ_D), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_done(txdone_q),
  .hold_full(hold_full_q), .wr_en(wr_en), .addr(addr), .rx_cnt(cnt_q),
  .rx_push(rx_done), .rx_pop(pop), .ovr(ovr_q), .rx_en(rx_en),
  .irq_rx(irq_rx), .irq_empty(irq_empty)
);

// File: tb/sio_port_test.sv
module sio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 12;

  logic             clk, rst_n, wr_en, rd_en, rxd;
  logic [1:0]       addr;
  logic [BUS_W-1:0] wdata, rdata;
  logic             txd, irq_rx, irq_empty, irq_txdone;

  int n_chk = 0;
  int n_fail = 0;

  sio_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq_rx(irq_rx),
    .irq_empty(irq_empty), .irq_txdone(irq_txdone)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 2'(a); wdata = BUS_W'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = 2'(a);
    #1 v = int'(rdata);
  endtask

  task automatic pop(output int v);
    @(negedge clk);
    addr = 2'd0; rd_en = 1'b1;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int ctl(int rxe, int txe, int ie, int n, int pm);
    return rxe | (txe << 1) | (ie << 2) | ((n - 6) << 5) | (pm << 7);
  endfunction

  // expected frame after the start bit: data LSB first, parity, stop
  function automatic int frame_bits(int d, int n, int pm, ref int b[12]);
    int k = 0;
    int x = 0;
    for (int i = 0; i < n; i++) begin
      b[k] = (d >> i) & 1; x ^= b[k]; k++;
    end
    if (pm >= 1 && pm <= 4) begin
      b[k] = (pm == 1) ? x : (pm == 2) ? (x ^ 1) : (pm == 3) ? 1 : 0; k++;
    end
    b[k] = 1; k++;
    return k;
  endfunction

  task automatic tx_check(string req, int d, int n, int pm, int per);
    int b[12];
    int cnt;
    int t = 0;
    cnt = frame_bits(d, n, pm, b);
    @(negedge clk);
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    repeat (per/2) @(negedge clk);
    chk({req, " start bit"}, int'(txd), 0);
    for (int i = 0; i < cnt; i++) begin
      repeat (per) @(negedge clk);
      chk($sformatf("%s bit %0d", req, i), int'(txd), b[i]);
    end
  endtask

  task automatic rx_send(int d, int n, int pm, int stopv, int per);
    int b[12];
    int cnt;
    cnt = frame_bits(d, n, pm, b);
    b[cnt-1] = stopv;
    @(negedge clk);
    rxd = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      rxd = b[i][0];
      repeat (per) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, t;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rxd = 1'b1; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(1, v); chk("R11 status", v, 'h002);
    chk("R11 txd", int'(txd), 1);
    chk("R11 irqs", int'({irq_rx, irq_empty, irq_txdone}), 0);

    wr(3, 1);
    wr(2, ctl(1, 1, 0, 8, 0));
    // R1 basic 8N1
    wr(0, 'hA5);
    tx_check("R1 8N1", 'hA5, 8, 0, 32);
    rd(1, v); chk("R5 done not before stop ends", (v >> 2) & 1, 0);
    repeat (24) @(negedge clk);
    rd(1, v); chk("R5 done after stop", (v >> 2) & 1, 1);
    wr(1, 4);
    rd(1, v); chk("R5 cleared by status write", (v >> 2) & 1, 0);

    // R2 / R3 formats
    wr(2, ctl(1, 1, 0, 7, 1)); wr(0, 'h53); tx_check("R3 7 even", 'h53, 7, 1, 32); repeat (24) @(negedge clk);
    wr(2, ctl(1, 1, 0, 6, 2)); wr(0, 'h2A); tx_check("R2 6 odd", 'h2A, 6, 2, 32); repeat (24) @(negedge clk);
    wr(2, ctl(1, 1, 0, 9, 3)); wr(0, 'h1C3); tx_check("R2 9 mark", 'h1C3, 9, 3, 32); repeat (24) @(negedge clk);
    wr(2, ctl(1, 1, 0, 8, 4)); wr(0, 'h81); tx_check("R3 8 space", 'h81, 8, 4, 32); repeat (24) @(negedge clk);
    wr(2, ctl(1, 1, 0, 9, 1)); wr(0, 'h155); tx_check("R3 9 even", 'h155, 9, 1, 32); repeat (24) @(negedge clk);

    // R10 tx disabled keeps char queued; R5 data write clears done
    wr(2, ctl(1, 0, 0, 8, 0));
    wr(0, 'h33);
    rd(1, v); chk("R5 cleared by data write", (v >> 2) & 1, 0);
    chk("R6 holding not empty", (v >> 1) & 1, 0);
    t = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) t++; end
    chk("R10 txd held high", t, 0);
    wr(2, ctl(1, 0, 'b110, 8, 0));
    chk("R6 irq_empty low while full", int'(irq_empty), 0);
    wr(2, ctl(1, 1, 'b110, 8, 0));
    tx_check("R10 queued char sent", 'h33, 8, 0, 32);
    chk("R6 irq_empty after take", int'(irq_empty), 1);
    repeat (24) @(negedge clk);
    chk("R6 irq_txdone", int'(irq_txdone), 1);
    wr(2, ctl(1, 1, 0, 8, 0));
    chk("R6 irqs masked", int'({irq_empty, irq_txdone}), 0);

    // R4 divisor
    wr(3, 3);
    wr(0, 'h01);
    @(negedge clk);
    t = 0;
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    t = 0;
    while (txd === 1'b0 && t < 4000) begin @(negedge clk); t++; end
    chk("R4 bit period div=3", t, 64);
    repeat (64 * 10) @(negedge clk);
    wr(3, 1);

    // R7 receive
    wr(2, ctl(1, 1, 1, 8, 0));
    rx_send('h5A, 8, 0, 1, 32);
    rd(1, v); chk("R7 rx done flag", v & 1, 1);
    chk("R7 irq_rx", int'(irq_rx), 1);
    pop(v); chk("R7 rx data", v, 'h5A);
    rd(1, v); chk("R7 flag cleared", v & 1, 0);

    // R8 order, R2 9-bit receive
    wr(2, ctl(1, 1, 0, 9, 1));
    rx_send('h1AB, 9, 1, 1, 32);
    rx_send('h0CD, 9, 1, 1, 32);
    pop(v); chk("R8 first", v, 'h1AB);
    pop(v); chk("R8 second", v, 'h0CD);

    // R8 overrun
    wr(2, ctl(1, 1, 0, 8, 0));
    rx_send('h01, 8, 0, 1, 32);
    rx_send('h02, 8, 0, 1, 32);
    rx_send('h03, 8, 0, 1, 32);
    rd(1, v); chk("R8 overrun set", (v >> 4) & 1, 1);
    pop(v); chk("R8 oldest kept", v, 'h01);
    rd(1, v); chk("R8 overrun cleared", (v >> 4) & 1, 0);
    pop(v); chk("R8 second kept", v, 'h02);
    rd(1, v); chk("R8 third discarded", v & 1, 0);

    // R9 framing error
    rx_send('h77, 8, 0, 0, 32);
    repeat (40) @(negedge clk);
    rd(1, v); chk("R9 framing flag", (v >> 3) & 1, 1);
    pop(v); chk("R9 data kept", v, 'h77);
    rd(1, v); chk("R9 flag gone", (v >> 3) & 1, 0);

    // R10 receiver disabled
    wr(2, ctl(0, 1, 0, 8, 0));
    rx_send('h44, 8, 0, 1, 32);
    rd(1, v); chk("R10 rx ignored", v & 1, 0);
    wr(2, ctl(1, 1, 0, 6, 3));
    rx_send('h26, 6, 3, 1, 32);
    pop(v); chk("R3 6-bit mark rx", v, 'h26);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule